// File: doc/BRIEF.md
# SPI flash command engine

This block runs one serial-flash command at a time on behalf of software. A 32-bit register port holds three words: a control word, a command word (command byte plus a 24-bit flash address), and a data word. Software fills the command word, and optionally the data word, while the engine is idle. It then writes the control word with a transmit byte count, a receive byte count and the start bit, and polls the busy bit until it clears.

While a transaction runs, the engine holds chip select low. It shifts out the counted transmit bytes, then clocks in the counted response bytes, and finally releases chip select. The transmit stream is the command byte, the three address bytes with the most significant first, and then further payload bytes taken from the data word starting with its lowest byte. Response bytes are packed into the data word starting at its lowest byte. The serial clock is the system clock divided by 2, 4, 8 or 16, chosen by a two-bit field.

The register port is plain control and status access with single-cycle writes and combinational reads. It has no back-pressure: a write that arrives while the engine is busy is simply dropped.

Top module: `spi_flash_cmd_engine`

## Requirements
- R1: Register words sit at byte address 0x0 (control), 0x4 (command) and 0x8 (data). The control word layout is: transmit count in bits [3:0], receive count in bits [7:4], start in bit 8 (always reads 0), busy in bit 16 (read only), a free two-bit size field in bits [18:17], and clock select in bits [25:24]. All other addresses read 0 and ignore writes.
- R2: After reset, chip select is high, the serial clock and MOSI are low, and all three register words read 0.
- R3: A control write with start set and a nonzero transmit count, made while idle, sets busy and drives chip select low from the next cycle. Busy falls one cycle after chip select returns high.
- R4: Transmit byte k is sent in this order: k=0 is command bits [7:0]; k=1..3 are command bits [31:24], [23:16] and [15:8]; k=4..7 are data bits [7:0], [15:8], [23:16] and [31:24]; k of 8 or more sends 0x00. Each byte goes out most significant bit first.
- R5: The serial protocol is SPI mode 0. The clock idles low, MOSI changes only on a falling clock edge or at the start of a transaction, and MISO is sampled on the rising edge.
- R6: Clock-select values 0, 1, 2 and 3 give serial-clock half periods of 1, 2, 4 and 8 system cycles.
- R7: Response bytes are clocked in after all transmit bytes, with MOSI held low. Response byte k (k<4) replaces data-word bits [8k+7:8k]. Response bytes beyond the fourth are discarded, and data-word bytes at positions not received keep their value.
- R8: Chip select stays low for exactly 16 × (tx + rx) × half-period cycles.
- R9: A start with a transmit count of 0 sends nothing: busy stays low and chip select stays high. The count fields are still stored.
- R10: Every register write made while busy, including one with start set, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench builds the engine with its default parameters: a four-bit count per direction and a two-bit clock select. This brings every divisor from 2 to 16 into reach, along with transmit counts past eight that run into the zero-filled byte positions. It also allows receive counts past four, which exercise the discard of extra response bytes. A behavioural model predicts chip select, clock, MOSI and the readable registers in every cycle. Directed transactions cover a status read, a signature read, an eight-byte program, an overlong read, a zero-length start, and writes issued while busy.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int CTL_START = 8;

  typedef enum logic [1:0] {SQ_IDLE, SQ_SHIFT, SQ_END} sq_state_t;

  // Byte k of the outgoing stream: command, address high-to-low, then payload low-to-high
  function automatic logic [7:0] tx_byte_sel(input logic [3:0] idx,
                                             input logic [31:0] op,
                                             input logic [31:0] dat);
    case (idx)
      4'd0:    return op[7:0];
      4'd1:    return op[31:24];
      4'd2:    return op[23:16];
      4'd3:    return op[15:8];
      4'd4:    return dat[7:0];
      4'd5:    return dat[15:8];
      4'd6:    return dat[23:16];
      4'd7:    return dat[31:24];
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/spi_eng_regs.sv
module spi_eng_regs import spi_eng_pkg::*; #(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 4,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              busy,
  input  logic              rx_we,
  input  logic [1:0]        rx_pos,
  input  logic [7:0]        rx_byte,
  output logic              go,
  output logic [CNT_W-1:0]  go_tx,
  output logic [CNT_W-1:0]  go_rx,
  output logic [SEL_W-1:0]  go_sel,
  output logic [31:0]       op_q,
  output logic [31:0]       dat_q
);
  logic [CNT_W-1:0] tx_q, rx_q;
  logic [SEL_W-1:0] sel_q;
  logic [1:0]       size_q;
  logic is_ctrl, is_op, is_dat, wr_ok;
  logic unused_wbits;

  assign is_ctrl = (bus_addr == ADDR_W'(0));
  assign is_op   = (bus_addr == ADDR_W'(4));
  assign is_dat  = (bus_addr == ADDR_W'(8));
  assign wr_ok   = bus_wr && !busy;

  assign go     = wr_ok && is_ctrl && bus_wdata[CTL_START];
  assign go_tx  = bus_wdata[CNT_W-1:0];
  assign go_rx  = bus_wdata[4 +: CNT_W];
  assign go_sel = bus_wdata[24 +: SEL_W];
  assign unused_wbits = ^{bus_wdata[31:26], bus_wdata[23:19], bus_wdata[16:9]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      sel_q  <= '0;
      size_q <= '0;
      op_q   <= '0;
      dat_q  <= '0;
    end else begin
      if (wr_ok) begin
        if (is_ctrl) begin
          tx_q   <= go_tx;
          rx_q   <= go_rx;
          sel_q  <= go_sel;
          size_q <= bus_wdata[18:17];
        end
        if (is_op)  op_q  <= bus_wdata;
        if (is_dat) dat_q <= bus_wdata;
      end
      if (rx_we) dat_q[{rx_pos, 3'b000} +: 8] <= rx_byte;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (is_ctrl) begin
      bus_rdata[CNT_W-1:0]  = tx_q;
      bus_rdata[4 +: CNT_W] = rx_q;
      bus_rdata[16]         = busy;
      bus_rdata[18:17]      = size_q;
      bus_rdata[24 +: SEL_W] = sel_q;
    end else if (is_op) begin
      bus_rdata = op_q;
    end else if (is_dat) begin
      bus_rdata = dat_q;
    end
  end

  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(op_q)); // R10
  AST_ZERO_TX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && is_ctrl && bus_wdata[CTL_START] && (go_tx == '0)) |=> !busy); // R9
endmodule

// File: rtl/spi_eng_clkdiv.sv
module spi_eng_clkdiv #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int HCNT_W = (1 << SEL_W) - 1;

  logic [HCNT_W-1:0] cnt, limit;

  assign limit = HCNT_W'((32'd1 << sel) - 32'd1);
  assign tick  = run && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || tick) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= limit)); // R6
endmodule

// File: rtl/spi_eng_seq.sv
module spi_eng_seq import spi_eng_pkg::*; #(
  parameter int CNT_W = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CNT_W-1:0] go_tx,
  input  logic [CNT_W-1:0] go_rx,
  input  logic [SEL_W-1:0] go_sel,
  input  logic [31:0]      op_q,
  input  logic [31:0]      dat_q,
  input  logic             tick,
  input  logic             miso,
  output logic             run,
  output logic [SEL_W-1:0] sel_q,
  output logic             busy,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi,
  output logic             rx_we,
  output logic [1:0]       rx_pos,
  output logic [7:0]       rx_byte
);
  localparam int IDX_W = CNT_W + 1;

  sq_state_t        state;
  logic [CNT_W-1:0] tx_n;
  logic [IDX_W-1:0] tot_n, byte_idx, nxt, rx_k;
  logic [2:0]       bit_idx;
  logic [7:0]       sh, nxt_byte, first_byte;
  logic [6:0]       rx_sh;

  assign run = (state == SQ_SHIFT);

  always_comb begin
    nxt        = byte_idx + 1'b1;
    nxt_byte   = (nxt < IDX_W'(tx_n)) ? tx_byte_sel(nxt[3:0], op_q, dat_q) : 8'h00;
    first_byte = tx_byte_sel(4'd0, op_q, dat_q);
    rx_k       = byte_idx - IDX_W'(tx_n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      busy     <= 1'b0;
      cs_n     <= 1'b1;
      sclk     <= 1'b0;
      mosi     <= 1'b0;
      tx_n     <= '0;
      tot_n    <= '0;
      sel_q    <= '0;
      byte_idx <= '0;
      bit_idx  <= '0;
      sh       <= '0;
      rx_sh    <= '0;
      rx_we    <= 1'b0;
      rx_pos   <= '0;
      rx_byte  <= '0;
    end else begin
      rx_we <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (go && (go_tx != '0)) begin
            state    <= SQ_SHIFT;
            busy     <= 1'b1;
            cs_n     <= 1'b0;
            tx_n     <= go_tx;
            tot_n    <= IDX_W'(go_tx) + IDX_W'(go_rx);
            sel_q    <= go_sel;
            byte_idx <= '0;
            bit_idx  <= '0;
            sh       <= first_byte;
            mosi     <= first_byte[7];
          end
        end
        SQ_SHIFT: begin
          if (tick) begin
            if (!sclk) begin
              sclk  <= 1'b1;
              rx_sh <= {rx_sh[5:0], miso};
              if ((bit_idx == 3'd7) && (byte_idx >= IDX_W'(tx_n)) && (rx_k < IDX_W'(4))) begin
                rx_we   <= 1'b1;
                rx_pos  <= rx_k[1:0];
                rx_byte <= {rx_sh, miso};
              end
            end else begin
              sclk <= 1'b0;
              if (bit_idx == 3'd7) begin
                if (byte_idx == tot_n - 1'b1) begin
                  cs_n  <= 1'b1;
                  mosi  <= 1'b0;
                  state <= SQ_END;
                end else begin
                  byte_idx <= nxt;
                  bit_idx  <= '0;
                  sh       <= nxt_byte;
                  mosi     <= nxt_byte[7];
                end
              end else begin
                bit_idx <= bit_idx + 1'b1;
                sh      <= {sh[6:0], 1'b0};
                mosi    <= sh[6];
              end
            end
          end
        end
        default: begin
          busy  <= 1'b0;
          state <= SQ_IDLE;
        end
      endcase
    end
  end

  AST_CS_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy); // R3
  AST_BUSY_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (cs_n && $past(cs_n))); // R3
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R5
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi)); // R5
endmodule

// File: rtl/spi_flash_cmd_engine.sv
module spi_flash_cmd_engine #(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 4,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  logic             go, busy, rx_we, run, tick;
  logic [CNT_W-1:0] go_tx, go_rx;
  logic [SEL_W-1:0] go_sel, sel_q;
  logic [31:0]      op_q, dat_q;
  logic [1:0]       rx_pos;
  logic [7:0]       rx_byte;

  spi_eng_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
    .rx_we(rx_we), .rx_pos(rx_pos), .rx_byte(rx_byte), .go(go),
    .go_tx(go_tx), .go_rx(go_rx), .go_sel(go_sel), .op_q(op_q), .dat_q(dat_q)
  );

  spi_eng_clkdiv #(.SEL_W(SEL_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .sel(sel_q), .tick(tick)
  );

  spi_eng_seq #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .go_tx(go_tx), .go_rx(go_rx),
    .go_sel(go_sel), .op_q(op_q), .dat_q(dat_q), .tick(tick), .miso(spi_miso),
    .run(run), .sel_q(sel_q), .busy(busy), .cs_n(spi_cs_n), .sclk(spi_sclk),
    .mosi(spi_mosi), .rx_we(rx_we), .rx_pos(rx_pos), .rx_byte(rx_byte)
  );
endmodule

// File: tb/sim_spi_flash_cmd_engine.sv
`timescale 1ns/1ps
module sim_spi_flash_cmd_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_cs_n, spi_sclk, spi_mosi;
  logic        spi_miso = 1'b0;

  int nchk = 0, nfail = 0, cyc = 0;

  spi_flash_cmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always #4 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  bit          m_busy, was;
  int          t, H = 1, N = 0;
  logic [3:0]  m_tx, m_rx;
  logic [1:0]  m_sel, m_size;
  logic [31:0] m_op, m_data;
  logic [7:0]  resp [16];

  function automatic logic [7:0] txb(input int j, input logic [31:0] op, input logic [31:0] d);
    if (j == 0) return op[7:0];
    if (j < 4)  return 8'(op >> (8 * (4 - j)));
    if (j < 8)  return 8'(d >> (8 * (j - 4)));
    return 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; t = 0; m_tx = 0; m_rx = 0; m_sel = 0; m_size = 0; m_op = 0; m_data = 0;
    end else begin
      was = m_busy;
      if (was) begin
        t = t + 1;
        if (t == 16 * N * H + 1) begin
          m_busy = 0;
          for (int k = 0; k < 4; k++)
            if (k < int'(m_rx)) m_data[8*k +: 8] = resp[k];
        end
      end else if (bus_wr) begin
        case (bus_addr)
          4'h0: begin
            m_tx = bus_wdata[3:0]; m_rx = bus_wdata[7:4];
            m_size = bus_wdata[18:17]; m_sel = bus_wdata[25:24];
            if (bus_wdata[8] && bus_wdata[3:0] != 0) begin
              m_busy = 1; t = 0; H = 1 << m_sel; N = int'(m_tx) + int'(m_rx);
            end
          end
          4'h4: m_op = bus_wdata;
          4'h8: m_data = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  // compare every cycle, away from the active edge; also plays the flash's MISO
  always @(negedge clk) begin
    logic e_cs, e_sclk, e_mosi;
    logic [7:0] tb_byte;
    int b, j, bi, end_t;
    if (rst_n) begin
      end_t = 16 * N * H;
      e_cs = 1'b1; e_sclk = 1'b0; e_mosi = 1'b0;
      spi_miso = 1'b0;
      if (m_busy && t < end_t) begin
        e_cs = 1'b0;
        e_sclk = ((t / H) % 2) == 1;
        b = t / (2 * H); j = b / 8; bi = 7 - (b % 8);
        if (j < int'(m_tx)) begin
          tb_byte = txb(j, m_op, m_data);
          e_mosi = tb_byte[bi];
          spi_miso = 1'b1;
        end else begin
          tb_byte = resp[j - int'(m_tx)];
          spi_miso = tb_byte[bi];
        end
      end
      chk("R8 cs_n", {31'b0, spi_cs_n}, {31'b0, e_cs});
      chk("R6 sclk", {31'b0, spi_sclk}, {31'b0, e_sclk});
      chk("R4 R5 mosi", {31'b0, spi_mosi}, {31'b0, e_mosi});
      case (bus_addr)
        4'h0: chk("R1 R3 ctrl", bus_rdata,
                  {6'b0, m_sel, 5'b0, m_size, m_busy, 7'b0, 1'b0, m_rx, m_tx});
        4'h4: chk("R1 cmd", bus_rdata, m_op);
        4'h8: if (!m_busy) chk("R1 R7 data", bus_rdata, m_data);
        default: chk("R1 unmapped", bus_rdata, 32'h0);
      endcase
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL R3 watchdog: busy act=1 exp=0");
      report();
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_wr = 1'b0; bus_addr = 4'h0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #2;
    bus_addr = a;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
    @(posedge clk); #2;
    bus_addr = 4'h0;
  endtask

  task automatic wait_idle;
    @(negedge clk);
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] ctl(input int sel, input int size, input bit st,
                                      input int rx, input int tx);
    return {6'b0, 2'(sel), 5'b0, 2'(size), 1'b0, 7'b0, st, 4'(rx), 4'(tx)};
  endfunction

  task automatic start_and_check(input logic [31:0] c);
    wr(4'h0, c);
    @(negedge clk);
    chk("R3 busy after start", {31'b0, bus_rdata[16]}, 32'h1);
    chk("R3 cs low after start", {31'b0, spi_cs_n}, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) resp[i] = 8'h00;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk("R2 cs_n reset", {31'b0, spi_cs_n}, 32'h1);
    chk("R2 sclk reset", {31'b0, spi_sclk}, 32'h0);
    chk("R2 mosi reset", {31'b0, spi_mosi}, 32'h0);
    rd_chk(4'h0, 32'h0, "R2 ctrl reset");
    rd_chk(4'h4, 32'h0, "R2 cmd reset");
    rd_chk(4'h8, 32'h0, "R2 data reset");

    // register map
    wr(4'h8, 32'h11223344);
    wr(4'hC, 32'hFFFFFFFF);
    rd_chk(4'hC, 32'h0, "R1 unmapped read");
    rd_chk(4'h8, 32'h11223344, "R1 data readback");

    // status read: 1 out, 1 in, divide by 2
    wr(4'h4, 32'h00000005);
    resp[0] = 8'h01;
    start_and_check(ctl(0, 0, 1, 1, 1));
    wait_idle();
    rd_chk(4'h8, 32'h11223301, "R7 status byte into low lane");

    // signature read: 4 out, 1 in, divide by 4, size field stored
    wr(4'h4, 32'h000000AB);
    resp[0] = 8'h17;
    start_and_check(ctl(1, 2, 1, 1, 4));
    wait_idle();
    rd_chk(4'h8, 32'h11223317, "R7 signature byte");
    rd_chk(4'h0, 32'h01040014, "R1 ctrl fields start reads 0");

    // program: 8 out, divide by 8
    wr(4'h4, 32'h00123402);
    wr(4'h8, 32'hCAFEF00D);
    start_and_check(ctl(2, 0, 1, 0, 8));
    wait_idle();
    rd_chk(4'h8, 32'hCAFEF00D, "R7 no receive keeps data");

    // overlong receive: 2 out, 6 in, divide by 16
    resp[0] = 8'h5A; resp[1] = 8'h3C; resp[2] = 8'h96;
    resp[3] = 8'hE1; resp[4] = 8'hFF; resp[5] = 8'h00;
    start_and_check(ctl(3, 0, 1, 6, 2));
    wait_idle();
    rd_chk(4'h8, 32'hE1963C5A, "R7 extra bytes discarded");

    // partial receive keeps upper lanes
    resp[0] = 8'hAA; resp[1] = 8'hBB;
    start_and_check(ctl(0, 0, 1, 2, 1));
    wait_idle();
    rd_chk(4'h8, 32'hE196BBAA, "R7 upper lanes kept");

    // nine transmit bytes: ninth is zero
    start_and_check(ctl(0, 0, 1, 0, 9));
    wait_idle();

    // zero transmit count
    wr(4'h0, ctl(0, 0, 1, 2, 0));
    @(negedge clk);
    chk("R9 busy stays low", {31'b0, bus_rdata[16]}, 32'h0);
    chk("R9 cs stays high", {31'b0, spi_cs_n}, 32'h1);
    repeat (4) @(negedge clk);
    chk("R9 still idle", {31'b0, spi_cs_n}, 32'h1);
    rd_chk(4'h0, 32'h00000020, "R9 counts stored");

    // writes while busy are ignored
    start_and_check(ctl(1, 0, 1, 0, 3));
    wr(4'h4, 32'hDEADBEEF);
    wr(4'h8, 32'h00000000);
    wr(4'h0, ctl(0, 0, 1, 1, 1));
    wait_idle();
    rd_chk(4'h4, 32'h00123402, "R10 cmd write dropped");
    rd_chk(4'h8, 32'hE196BBAA, "R10 data write dropped");
    rd_chk(4'h0, 32'h01000003, "R10 ctrl write dropped");
    chk("R10 no second transaction", {31'b0, spi_cs_n}, 32'h1);

    repeat (5) @(negedge clk);
    report();
    $finish;
  end
endmodule